// File: doc/BRIEF.md
# Programmable-Timing Asynchronous Memory Bus Controller

This block turns single requests from on-chip logic into access cycles on an asynchronous parallel memory bus with six chip-select lines. Every chip select carries its own timing: wait cycles for the strobe, a write hold, a turnaround gap after reads, extra latency on the first access to a page, a spacing between the address strobe and the output enable, and an optional extra cycle of address hold. A small configuration port loads two timing words and an enable bit for each chip select.

A request is taken only while the sequencer is idle. Requests to a chip select that does not exist or is not enabled are refused with an error pulse and cause no bus activity. Accepted requests run through the phases turnaround, address strobe, gap, strobe and write hold. A one-clock done pulse ends each access, and read data comes back with that pulse. The data pins are split into output, output-enable and input so that the pad ring can form the bidirectional bus.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset all chip selects, output enable, write enable and address strobe are high (inactive), the data bus is not driven, the address output is zero, the request interface is ready and no done or error pulse is raised.
- R2: A request to a chip-select index of 6 or above, or to a chip select whose enable bit is clear, raises the error output for one clock in the cycle after it is presented, leaves every bus pin inactive and does not change recovery or page state.
- R3: Every accepted access drives the address strobe low for exactly one cycle, with the chosen chip select low and the address on the address pins. When the fast word's bit 5 (address hold) is set, the address stays on the pins for the cycle after that. In every other cycle the address pins are zero.
- R4: For a read, the number of cycles between the address strobe cycle and the first output-enable cycle equals the largest of the fast word's read-lead field [27:24], its strobe-to-enable field [17:16] and the address hold bit, plus any first-access latency.
- R5: Output enable stays low for slow word field [3:0] plus one cycles. Read data is taken from the bus at the end of the last of those cycles and appears on the read-data output together with done.
- R6: For a write, the gap after the address strobe is the address hold bit plus any first-access latency. Write enable then stays low for slow field [7:4] plus one cycles, and the chip select stays low afterwards for slow field [27:24] cycles, or one cycle when that field is zero. Write data is driven from the first write-enable cycle to the end of the hold.
- R7: First-access latency, slow field [15:8] for reads and [23:16] for writes, is added only when the address bits above bit 3 differ from the last accepted access to that chip select, or when none has happened since reset or since the last configuration write to that chip select.
- R8: When the previous accepted access was a read and the new one goes to another chip select or is a write, all chip selects stay high for the read chip select's slow field [31:28] plus one cycles before the address strobe. In all other cases no such cycles are inserted.
- R9: Done is high for exactly one clock, in the cycle after the last bus cycle of an access. Ready is high only when no access is in progress.
- R10: Configuration writes select the word by a kind code: 0 writes the slow word, 1 writes the fast word, 2 writes the enable bit from data bit 0. Writes to an index of 6 or above are ignored.
- R11: The data bus is driven only during write-enable and write-hold cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cs | input | 3 | Chip select addressed by the configuration write |
| cfg_kind | input | 2 | 0 slow word, 1 fast word, 2 enable bit |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 3 | Chip-select index of the request |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| rsp_done | output | 1 | One-clock end-of-access pulse |
| rsp_err | output | 1 | One-clock refused-request pulse |
| rsp_rdata | output | 16 | Read data, valid with done after a read |
| mem_cs_n | output | 6 | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address strobe, active low |
| mem_addr | output | 24 | Address pins |
| mem_data_out | output | 16 | Data driven toward memory |
| mem_data_oe | output | 1 | Drive enable for the data pins |
| mem_data_in | input | 16 | Data read from the pins |

## Verification
The sequences are built so that each timing term can be seen on its own. Two reads in one page separate the first-access latency from the fixed gap, and a read to a new page brings it back. A read followed by a write on the same chip select, a read followed by a read on another, a read after a write and a read after a read on the same chip select separate the four turnaround cases. Chip selects are set up with the read lead above, below and equal to the strobe-to-enable spacing, with and without address hold, and with the longest write latency and strobe. Refused requests are placed between a read and a write so that any leak into the turnaround or page state would change the timing of the next access.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REC  = 3'd1,
        ST_ADV  = 3'd2,
        ST_GAP  = 3'd3,
        ST_STRB = 3'd4,
        ST_HOLD = 3'd5
    } seq_state_e;

    localparam logic [1:0] KIND_SLOW = 2'd0;
    localparam logic [1:0] KIND_FAST = 2'd1;
    localparam logic [1:0] KIND_EN   = 2'd2;

    // packed fast word kept in the bank: {read lead[3:0], strobe-to-enable[1:0], addr hold}
    localparam int FASTW = 7;

    function automatic logic [FASTW-1:0] fast_pack(input logic [31:0] w);
        return {w[27:24], w[17:16], w[5]};
    endfunction

    function automatic logic [3:0] fw_lead(input logic [FASTW-1:0] f);
        return f[6:3];
    endfunction

    function automatic logic [1:0] fw_adv2oe(input logic [FASTW-1:0] f);
        return f[2:1];
    endfunction

    function automatic logic fw_ahold(input logic [FASTW-1:0] f);
        return f[0];
    endfunction

    function automatic logic [3:0] sw_rec(input logic [31:0] w);
        return w[31:28];
    endfunction

    function automatic logic [3:0] sw_whold(input logic [31:0] w);
        return w[27:24];
    endfunction

    function automatic logic [7:0] sw_wlat(input logic [31:0] w);
        return w[23:16];
    endfunction

    function automatic logic [7:0] sw_rlat(input logic [31:0] w);
        return w[15:8];
    endfunction

    function automatic logic [3:0] sw_wwait(input logic [31:0] w);
        return w[7:4];
    endfunction

    function automatic logic [3:0] sw_rwait(input logic [31:0] w);
        return w[3:0];
    endfunction

endpackage

// File: rtl/ebc_cfg_bank.sv
module ebc_cfg_bank
    import ebc_pkg::*;
#(
    parameter int NCS = 6,
    parameter int CSW = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [CSW-1:0]              wr_cs,
    input  logic [1:0]                  wr_kind,
    input  logic [31:0]                 wr_data,
    output logic [NCS-1:0][31:0]        slow_cfg,
    output logic [NCS-1:0][FASTW-1:0]   fast_cfg,
    output logic [NCS-1:0]              cs_en,
    output logic                        touch,
    output logic [CSW-1:0]              touch_cs
);

    typedef struct packed {
        logic [NCS-1:0][31:0]      slow;
        logic [NCS-1:0][FASTW-1:0] fast;
        logic [NCS-1:0]            en;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  in_range;

    assign in_range = ({1'b0, wr_cs} < (CSW+1)'(NCS));

    always_comb begin
        bank_d = bank_q;
        if (wr_en && in_range) begin
            unique case (wr_kind)
                KIND_SLOW: bank_d.slow[wr_cs] = wr_data;
                KIND_FAST: bank_d.fast[wr_cs] = fast_pack(wr_data);
                KIND_EN:   bank_d.en[wr_cs]   = wr_data[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign slow_cfg = bank_q.slow;
    assign fast_cfg = bank_q.fast;
    assign cs_en    = bank_q.en;
    assign touch    = wr_en && in_range;
    assign touch_cs = wr_cs;

endmodule

// File: rtl/ebc_page_track.sv
module ebc_page_track #(
    parameter int NCS = 6,
    parameter int CSW = 3,
    parameter int PW  = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_en,
    input  logic [CSW-1:0] clr_cs,
    input  logic           upd_en,
    input  logic [CSW-1:0] acc_cs,
    input  logic [PW-1:0]  acc_page,
    output logic           first
);

    logic [NCS-1:0]         vld_d, vld_q;
    logic [NCS-1:0][PW-1:0] tag_d, tag_q;
    logic [NCS-1:0]         hit;

    generate
        for (genvar i = 0; i < NCS; i++) begin : g_hit
            assign hit[i] = vld_q[i] && (tag_q[i] == acc_page);
        end
    endgenerate

    assign first = !hit[acc_cs];

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        for (int i = 0; i < NCS; i++) begin
            if (upd_en && (acc_cs == CSW'(i))) begin
                vld_d[i] = 1'b1;
                tag_d[i] = acc_page;
            end
            if (clr_en && (clr_cs == CSW'(i))) begin
                vld_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            tag_q <= '0;
        end else begin
            vld_q <= vld_d;
            tag_q <= tag_d;
        end
    end

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int NCS = 6,
    parameter int CSW = 3,
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int CW  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ok,
    input  logic              req_write,
    input  logic [CSW-1:0]    req_cs,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [31:0]       sel_slow,
    input  logic [FASTW-1:0]  sel_fast,
    input  logic [3:0]        rec_field,
    input  logic              first_acc,
    input  logic [DW-1:0]     mem_data_in,
    output logic              req_ready,
    output logic              start,
    output logic [CSW-1:0]    last_cs,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DW-1:0]     rsp_rdata,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_data_out,
    output logic              mem_data_oe
);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
        logic [CW-1:0]  gap;
        logic [4:0]     strb;
        logic [4:0]     hold;
        logic           wr;
        logic           ah;
        logic           ahold;
        logic [CSW-1:0] cs;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic           last_rd;
        logic [CSW-1:0] last_cs;
        logic           done;
        logic           err;
        logic [DW-1:0]  rdata;
    } seq_t;

    seq_t q, d;

    logic [3:0]    lead;
    logic [CW-1:0] rd_gap, wr_gap;
    logic [4:0]    strb_len, hold_len;
    logic          need_rec;
    logic          bus_on;

    // timing of the request being offered, from its chip select's words
    always_comb begin
        lead = fw_lead(sel_fast);
        if ({2'b00, fw_adv2oe(sel_fast)} > lead) begin
            lead = {2'b00, fw_adv2oe(sel_fast)};
        end
        if ({3'b000, fw_ahold(sel_fast)} > lead) begin
            lead = {3'b000, fw_ahold(sel_fast)};
        end
        rd_gap   = CW'(lead) + (first_acc ? CW'(sw_rlat(sel_slow)) : '0);
        wr_gap   = CW'(fw_ahold(sel_fast)) + (first_acc ? CW'(sw_wlat(sel_slow)) : '0);
        strb_len = req_write ? ({1'b0, sw_wwait(sel_slow)} + 5'd1)
                             : ({1'b0, sw_rwait(sel_slow)} + 5'd1);
        hold_len = (sw_whold(sel_slow) == 4'd0) ? 5'd1 : {1'b0, sw_whold(sel_slow)};
        need_rec = q.last_rd && ((req_cs != q.last_cs) || req_write);
    end

    assign start = (q.st == ST_IDLE) && req_valid && req_ok;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.err   = 1'b0;
        d.ahold = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid && !req_ok) begin
                    d.err = 1'b1;
                end else if (start) begin
                    d.wr      = req_write;
                    d.cs      = req_cs;
                    d.addr    = req_addr;
                    d.wdata   = req_wdata;
                    d.ah      = fw_ahold(sel_fast);
                    d.gap     = req_write ? wr_gap : rd_gap;
                    d.strb    = strb_len;
                    d.hold    = hold_len;
                    d.last_rd = !req_write;
                    d.last_cs = req_cs;
                    if (need_rec) begin
                        d.st  = ST_REC;
                        d.cnt = CW'(rec_field);
                    end else begin
                        d.st  = ST_ADV;
                    end
                end
            end
            ST_REC: begin
                if (q.cnt == '0) begin
                    d.st = ST_ADV;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ADV: begin
                d.ahold = q.ah;
                if (q.gap == '0) begin
                    d.st  = ST_STRB;
                    d.cnt = CW'(q.strb - 5'd1);
                end else begin
                    d.st  = ST_GAP;
                    d.cnt = q.gap - 1'b1;
                end
            end
            ST_GAP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_STRB;
                    d.cnt = CW'(q.strb - 5'd1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STRB: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (q.wr) begin
                    d.st  = ST_HOLD;
                    d.cnt = CW'(q.hold - 5'd1);
                end else begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.rdata = mem_data_in;
                end
            end
            ST_HOLD: begin
                if (q.cnt == '0) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bus_on = (q.st == ST_ADV) || (q.st == ST_GAP) ||
                    (q.st == ST_STRB) || (q.st == ST_HOLD);

    assign req_ready    = (q.st == ST_IDLE);
    assign last_cs      = q.last_cs;
    assign rsp_done     = q.done;
    assign rsp_err      = q.err;
    assign rsp_rdata    = q.rdata;
    assign mem_cs_n     = bus_on ? ~(NCS'(1) << q.cs) : '1;
    assign mem_adv_n    = !(q.st == ST_ADV);
    assign mem_oe_n     = !((q.st == ST_STRB) && !q.wr);
    assign mem_we_n     = !((q.st == ST_STRB) && q.wr);
    assign mem_data_oe  = q.wr && ((q.st == ST_STRB) || (q.st == ST_HOLD));
    assign mem_data_out = mem_data_oe ? q.wdata : '0;
    assign mem_addr     = ((q.st == ST_ADV) || q.ahold) ? q.addr : '0;

endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
    import ebc_pkg::*;
#(
    parameter int NCS      = 6,
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int PAGE_LSB = 4,
    localparam int CSW     = (NCS > 1) ? $clog2(NCS + 1) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CSW-1:0]  cfg_cs,
    input  logic [1:0]      cfg_kind,
    input  logic [31:0]     cfg_wdata,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [CSW-1:0]  req_cs,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_ready,
    output logic            rsp_done,
    output logic            rsp_err,
    output logic [DW-1:0]   rsp_rdata,
    output logic [NCS-1:0]  mem_cs_n,
    output logic            mem_oe_n,
    output logic            mem_we_n,
    output logic            mem_adv_n,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_data_out,
    output logic            mem_data_oe,
    input  logic [DW-1:0]   mem_data_in
);

    localparam int PW = AW - PAGE_LSB;
    localparam int CW = $clog2(16 + 256);

    logic [NCS-1:0][31:0]      slow_cfg;
    logic [NCS-1:0][FASTW-1:0] fast_cfg;
    logic [NCS-1:0]            cs_en;
    logic                      touch;
    logic [CSW-1:0]            touch_cs;
    logic                      cs_in_range;
    logic [CSW-1:0]            cs_idx;
    logic                      req_ok;
    logic                      first_acc;
    logic                      start;
    logic [CSW-1:0]            last_cs;
    logic [3:0]                rec_field;

    ebc_cfg_bank #(.NCS(NCS), .CSW(CSW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_cs    (cfg_cs),
        .wr_kind  (cfg_kind),
        .wr_data  (cfg_wdata),
        .slow_cfg (slow_cfg),
        .fast_cfg (fast_cfg),
        .cs_en    (cs_en),
        .touch    (touch),
        .touch_cs (touch_cs)
    );

    assign cs_in_range = ({1'b0, req_cs} < (CSW+1)'(NCS));
    assign cs_idx      = cs_in_range ? req_cs : '0;
    assign req_ok      = cs_in_range && cs_en[cs_idx];
    assign rec_field   = sw_rec(slow_cfg[last_cs]);

    ebc_page_track #(.NCS(NCS), .CSW(CSW), .PW(PW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (touch),
        .clr_cs   (touch_cs),
        .upd_en   (start),
        .acc_cs   (cs_idx),
        .acc_page (req_addr[AW-1:PAGE_LSB]),
        .first    (first_acc)
    );

    ebc_seq #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ok       (req_ok),
        .req_write    (req_write),
        .req_cs       (cs_idx),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .sel_slow     (slow_cfg[cs_idx]),
        .sel_fast     (fast_cfg[cs_idx]),
        .rec_field    (rec_field),
        .first_acc    (first_acc),
        .mem_data_in  (mem_data_in),
        .req_ready    (req_ready),
        .start        (start),
        .last_cs      (last_cs),
        .rsp_done     (rsp_done),
        .rsp_err      (rsp_err),
        .rsp_rdata    (rsp_rdata),
        .mem_cs_n     (mem_cs_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_adv_n    (mem_adv_n),
        .mem_addr     (mem_addr),
        .mem_data_out (mem_data_out),
        .mem_data_oe  (mem_data_oe)
    );

endmodule

// File: rtl/ext_mem_ctrl_chk.sv
module ext_mem_ctrl_chk #(
    parameter int NCS = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           rsp_done,
    input logic           rsp_err,
    input logic [NCS-1:0] mem_cs_n,
    input logic           mem_oe_n,
    input logic           mem_we_n,
    input logic           mem_adv_n,
    input logic           mem_data_oe
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n)); // R3

    AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |=> mem_adv_n); // R3

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !(&mem_cs_n)); // R4

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R5

    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!(&mem_cs_n) && mem_data_oe)); // R6

    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (&mem_cs_n && !rsp_done)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n)); // R9

    AST_DATA_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_data_oe |-> (mem_oe_n && !(&mem_cs_n))); // R11

endmodule

bind ext_mem_ctrl ext_mem_ctrl_chk #(.NCS(NCS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_adv_n   (mem_adv_n),
    .mem_data_oe (mem_data_oe)
);

// File: tb/sim_ext_mem_ctrl.sv
module sim_ext_mem_ctrl;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_cs = '0;
    logic [1:0]  cfg_kind = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_cs = '0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic [5:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_adv_n, mem_data_oe;
    logic [23:0] mem_addr;
    logic [15:0] mem_data_out;
    logic [15:0] mem_data_in = '0;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int slow_m [6];
    int fast_m [6];
    bit en_m   [6];
    bit pv     [6];
    int ptag   [6];
    bit lrd = 0;
    int lcs = 0;

    always #(CLK_P/2) clk = ~clk;

    ext_mem_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
        .mem_addr(mem_addr), .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe),
        .mem_data_in(mem_data_in)
    );

    task automatic cyc_chk(input string tag, input logic [5:0] ecs, input logic eadv,
                           input logic eoe, input logic ewe, input logic edoe,
                           input logic [23:0] ea, input logic [15:0] edo,
                           input logic erdy, input logic edone, input logic eerr);
        logic [37:0] got, exp;
        got = {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_data_oe, req_ready, rsp_done, rsp_err,
               mem_addr[7:0], mem_data_out, 1'b0};
        exp = {ecs, eadv, eoe, ewe, edoe, erdy, edone, eerr, ea[7:0], edo, 1'b0};
        n_chk++;
        if (got !== exp || mem_addr !== ea) begin
            n_fail++;
            $display("FAIL %s t=%0t: got cs=%b adv=%b oe=%b we=%b doe=%b rdy=%b done=%b err=%b addr=%h dout=%h ; expected cs=%b adv=%b oe=%b we=%b doe=%b rdy=%b done=%b err=%b addr=%h dout=%h",
                     tag, $time, mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_data_oe, req_ready,
                     rsp_done, rsp_err, mem_addr, mem_data_out,
                     ecs, eadv, eoe, ewe, edoe, erdy, edone, eerr, ea, edo);
        end
    endtask

    task automatic cfg_write(input int kind, input int cs, input int data);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_cs = 3'(cs); cfg_wdata = 32'(data);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        if (cs < 6 && kind < 3) begin
            pv[cs] = 1'b0;
            if (kind == 0) slow_m[cs] = data;
            else if (kind == 1) fast_m[cs] = data;
            else en_m[cs] = data[0];
        end
        // R10: configuration leaves the bus idle
        cyc_chk("R10", 6'h3f, 1, 1, 1, 0, 24'h0, 16'h0, 1, 0, 0);
    endtask

    task automatic do_req(input bit wr, input int cs, input int addr, input int wd);
        bit ok, first, need_rec;
        int r_n, g_n, s_n, h_n, n_all, pg, rhold, advoe, ah, lead;
        logic [15:0] pat;
        ok = (cs < 6) && en_m[cs];
        req_valid = 1'b1; req_write = wr; req_cs = 3'(cs);
        req_addr = 24'(addr); req_wdata = 16'(wd);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!ok) begin
            cyc_chk("R2", 6'h3f, 1, 1, 1, 0, 24'h0, 16'h0, 1, 0, 1);
            return;
        end
        pg = addr >> 4;
        first = !pv[cs] || (ptag[cs] != pg);
        pv[cs] = 1'b1; ptag[cs] = pg;
        need_rec = lrd && ((cs != lcs) || wr);
        r_n = need_rec ? (((slow_m[lcs] >> 28) & 15) + 1) : 0;
        lrd = !wr; lcs = cs;
        ah = (fast_m[cs] >> 5) & 1;
        rhold = (fast_m[cs] >> 24) & 15;
        advoe = (fast_m[cs] >> 16) & 3;
        if (wr) begin
            g_n = ah + (first ? ((slow_m[cs] >> 16) & 255) : 0);
            s_n = ((slow_m[cs] >> 4) & 15) + 1;
            h_n = (slow_m[cs] >> 24) & 15;
            if (h_n == 0) h_n = 1;
        end else begin
            lead = rhold;
            if (advoe > lead) lead = advoe;
            if (ah > lead) lead = ah;
            g_n = lead + (first ? ((slow_m[cs] >> 8) & 255) : 0);
            s_n = (slow_m[cs] & 15) + 1;
            h_n = 0;
        end
        n_all = r_n + 1 + g_n + s_n + h_n;
        pat = 16'(addr) ^ 16'hA5C3;
        for (int k = 1; k <= n_all; k++) begin
            logic [5:0]  ecs;
            logic        eadv, eoe, ewe, edoe;
            logic [23:0] ea;
            string       tag;
            ecs = ~(6'b1 << cs); eadv = 1; eoe = 1; ewe = 1; edoe = 0; ea = '0;
            if (k <= r_n) begin
                ecs = 6'h3f; tag = "R8";
            end else if (k == r_n + 1) begin
                eadv = 0; ea = 24'(addr); tag = "R3";
            end else if (k <= r_n + 1 + g_n) begin
                tag = first ? "R7" : (wr ? "R6" : "R4");
                if (k == r_n + 2 && ah == 1) begin
                    ea = 24'(addr); tag = "R3";
                end
            end else if (k <= r_n + 1 + g_n + s_n) begin
                tag = wr ? "R6" : "R5";
                if (wr) begin ewe = 0; edoe = 1; end
                else eoe = 0;
            end else begin
                tag = "R11"; edoe = 1;
            end
            cyc_chk(tag, ecs, eadv, eoe, ewe, edoe, ea, edoe ? 16'(wd) : 16'h0, 0, 0, 0);
            mem_data_in = (!wr && k == r_n + 1 + g_n + s_n) ? pat : ~pat;
            @(negedge clk);
        end
        cyc_chk("R9", 6'h3f, 1, 1, 1, 0, 24'h0, 16'h0, 1, 1, 0);
        if (!wr) begin
            n_chk++;
            if (rsp_rdata !== pat) begin
                n_fail++;
                $display("FAIL R5: read data got %h expected %h", rsp_rdata, pat);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            slow_m[i] = 0; fast_m[i] = 0; en_m[i] = 0; pv[i] = 0; ptag[i] = 0;
        end
        repeat (3) @(negedge clk);
        cyc_chk("R1", 6'h3f, 1, 1, 1, 0, 24'h0, 16'h0, 1, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        cyc_chk("R1", 6'h3f, 1, 1, 1, 0, 24'h0, 16'h0, 1, 0, 0);

        // R2: disabled chip select refused
        do_req(0, 0, 24'h10, 0);
        // R10: program timing words and enables
        cfg_write(0, 0, 32'h2003_0512);
        cfg_write(1, 0, 32'h0102_0000);
        cfg_write(2, 0, 1);
        cfg_write(0, 1, 32'h0300_0000);
        cfg_write(1, 1, 32'h0000_0020);
        cfg_write(2, 1, 1);
        cfg_write(0, 3, 32'h00FF_00FF);
        cfg_write(1, 3, 32'h0401_0020);
        cfg_write(2, 3, 1);
        cfg_write(2, 2, 1);
        // R10: out-of-range index ignored, R2: index 6 and 7 refused
        cfg_write(2, 6, 1);
        do_req(0, 6, 24'h40, 0);
        do_req(1, 7, 24'h40, 16'h1111);

        // R4 R5 R7: first read, then same page, then new page
        do_req(0, 0, 24'h000010, 0);
        do_req(0, 0, 24'h000014, 0);
        do_req(0, 0, 24'h000020, 0);
        // R2 between a read and a write must not disturb turnaround
        do_req(0, 4, 24'h30, 0);
        // R8: read then write on same chip select
        do_req(1, 0, 24'h000024, 16'hBEEF);
        // R8: write then read elsewhere, no turnaround; R3 address hold
        do_req(0, 1, 24'h000100, 0);
        // R8: read then read on other chip select
        do_req(0, 0, 24'h000028, 0);
        // R6: long write hold on chip select 1, turnaround first
        do_req(1, 1, 24'h000104, 16'h5A5A);
        // R6: zero hold field still gives one hold cycle
        do_req(1, 0, 24'h00002C, 16'h0F0F);
        // R7: reconfiguration clears page memory
        cfg_write(1, 0, 32'h0102_0000);
        do_req(0, 0, 24'h000020, 0);
        // R4: all-zero timing on chip select 2
        do_req(0, 2, 24'h000200, 0);
        // R4 R5 R6 R7: lead larger than spacing, longest wait and write latency
        do_req(0, 3, 24'hABCDE0, 0);
        do_req(1, 3, 24'hABCDE4, 16'hC0DE);
        do_req(1, 3, 24'h123450, 16'h7777);
        // R2: disabling refuses further requests
        cfg_write(2, 1, 0);
        do_req(0, 1, 24'h000100, 0);
        do_req(0, 2, 24'h000204, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule